// File: doc/BRIEF.md
# Upstream Burst Preamble Sequencer

This block starts each upstream burst. It takes delayed line characters, each with a control flag, together with a level that says whether frames are waiting to be sent. For each burst it produces a 66-bit preamble stream for the gearbox. While the optical transmitter settles, the block sends clock-recovery words made of alternating ones and zeros. It then sends one or more fixed delimiter words. After that it passes characters straight through to the encoding path. A new 66-bit word is built once for every four characters that arrive, and a character counts only on a cycle where `char_valid_i` is high.

The block raises a one-cycle laser-on request as soon as it sees pending data in the clock-recovery phase. It moves to the delimiter phase once a set number of clock-recovery words have gone out while data stayed pending. When the last delimiter word has been written, it pulses a reset for the downstream rate adapter, encoder, scrambler and FEC, and it enters the data phase. It stays in the data phase until the pending level drops, and then returns to clock recovery. Turning the laser off is left to the FEC encoder.

Top module: `burst_preamble_ctrl`

## Requirements
- R1: While `rst_ni` is low, `phase_o` reads 0 and `laser_on_o`, `path_rst_o`, `word_valid_o` and `data_valid_o` are all low.
- R2: `phase_o` encodes clock recovery as 0, delimiter as 1 and data as 2, and it never reads 3.
- R3: In phases 0 and 1, `word_valid_o` is high for exactly the one cycle after the clock edge that takes in the fourth character of a group. Cycles with `char_valid_i` low do not count toward the group.
- R4: A word emitted in phase 0 is the alternating pattern with bit 65 set, and every odd bit is 1 while every even bit is 0.
- R5: In phase 0, `laser_on_o` pulses for one cycle after the first edge at which `pending_i` is high. It does not pulse again until the block has come back from phase 2.
- R6: Phase 0 moves to phase 1 on the edge that emits the SYNC_WORDS-th clock-recovery word counted while `pending_i` is high. Any edge in phase 0 with `pending_i` low restarts this count.
- R7: A word emitted in phase 1 equals `DELIM_PATTERN`, and `pending_i` has no effect in phase 1.
- R8: On the edge that emits the DELIM_WORDS-th delimiter word, `path_rst_o` pulses for one cycle while `phase_o` becomes 2.
- R9: In phase 2 no words are emitted. Each character is forwarded one cycle later on `data_valid_o`, with `data_o` set to {control flag, character}.
- R10: In phase 2, an edge with `pending_i` low returns `phase_o` to 0 on the next cycle. The next burst then builds its first group from four new characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | A delayed character is dequeued this cycle |
| char_i | input | CHAR_W | Character value |
| char_ctrl_i | input | 1 | Character is a control code |
| pending_i | input | 1 | Non-idle data is waiting |
| laser_on_o | output | 1 | One-cycle laser-on request |
| path_rst_o | output | 1 | One-cycle reset of the downstream data path |
| word_valid_o | output | 1 | Preamble word strobe |
| word_o | output | WORD_W | Preamble word toward the gearbox |
| data_valid_o | output | 1 | Forwarded character strobe |
| data_o | output | CHAR_W+1 | Forwarded {control flag, character} |
| phase_o | output | 2 | Current phase |

## Verification
The bench first sends a steady stream of characters with nothing pending. This shows that clock-recovery words are built even though no laser request is raised. It then sends characters only on alternate cycles, which checks that idle cycles never count toward a word. In a burst where `pending_i` drops partway through clock recovery, a design that does not restart the SyncTime count enters the delimiter phase early, and the bench sees the difference. During the delimiter phase `pending_i` toggles on every character to show that it is ignored there. A second full burst follows the return from the data phase, and it must produce a new laser request and start from a fresh character group.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    PH_CDR   = 2'd0,
    PH_FRAME = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;
endpackage

// File: rtl/bpc_char_cnt.sv
module bpc_char_cnt #(
  parameter int CHARS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic last_o
);
  localparam int CW = (CHARS > 1) ? $clog2(CHARS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHARS - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = adv_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bpc_fsm.sv
module bpc_fsm
  import bpc_pkg::*;
#(
  parameter int SYNC_WORDS  = 4,
  parameter int DELIM_WORDS = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pending_i,
  input  logic   word_done_i,
  output phase_e phase_o,
  output logic   laser_on_o,
  output logic   path_rst_o
);
  localparam int SCW = (SYNC_WORDS > 1) ? $clog2(SYNC_WORDS) : 1;
  localparam int DCW = (DELIM_WORDS > 1) ? $clog2(DELIM_WORDS) : 1;
  localparam logic [SCW-1:0] SYNC_LAST  = SCW'(SYNC_WORDS - 1);
  localparam logic [DCW-1:0] DELIM_LAST = DCW'(DELIM_WORDS - 1);

  phase_e         phase_q, phase_d;
  logic [SCW-1:0] sync_q, sync_d;
  logic [DCW-1:0] delim_q, delim_d;
  logic           armed_q, armed_d;
  logic           laser_d, prst_d;

  always_comb begin
    phase_d = phase_q;
    sync_d  = sync_q;
    delim_d = delim_q;
    armed_d = armed_q;
    laser_d = 1'b0;
    prst_d  = 1'b0;
    unique case (phase_q)
      PH_CDR: begin
        if (pending_i && armed_q) begin
          laser_d = 1'b1;
          armed_d = 1'b0;
        end
        if (!pending_i) begin
          sync_d = '0;
        end else if (word_done_i) begin
          if (sync_q == SYNC_LAST) begin
            phase_d = PH_FRAME;
            sync_d  = '0;
          end else begin
            sync_d = sync_q + 1'b1;
          end
        end
      end
      PH_FRAME: begin
        // pending is ignored until the delimiter is complete
        if (word_done_i) begin
          if (delim_q == DELIM_LAST) begin
            phase_d = PH_DATA;
            prst_d  = 1'b1;
            delim_d = '0;
          end else begin
            delim_d = delim_q + 1'b1;
          end
        end
      end
      PH_DATA: begin
        if (!pending_i) begin
          phase_d = PH_CDR;
          armed_d = 1'b1;
          sync_d  = '0;
        end
      end
      default: phase_d = PH_CDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CDR;
      sync_q     <= '0;
      delim_q    <= '0;
      armed_q    <= 1'b1;
      laser_on_o <= 1'b0;
      path_rst_o <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      sync_q     <= sync_d;
      delim_q    <= delim_d;
      armed_q    <= armed_d;
      laser_on_o <= laser_d;
      path_rst_o <= prst_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bpc_word_gen.sv
module bpc_word_gen
  import bpc_pkg::*;
#(
  parameter int                WORD_W        = 66,
  parameter logic [WORD_W-1:0] DELIM_PATTERN = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_done_i,
  input  phase_e            phase_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sync_w;

  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_sync
    assign sync_w[gi] = (gi % 2) == 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= word_done_i;
      if (word_done_i) word_o <= (phase_i == PH_CDR) ? sync_w : DELIM_PATTERN;
    end
  end
endmodule

// File: rtl/burst_preamble_ctrl.sv
module burst_preamble_ctrl
  import bpc_pkg::*;
#(
  parameter int                CHAR_W         = 8,
  parameter int                WORD_W         = 66,
  parameter int                CHARS_PER_WORD = 4,
  parameter int                SYNC_WORDS     = 4,
  parameter int                DELIM_WORDS    = 1,
  parameter logic [WORD_W-1:0] DELIM_PATTERN  = 66'h2_B5E3_0F4C_9A27_D861
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              char_ctrl_i,
  input  logic              pending_i,
  output logic              laser_on_o,
  output logic              path_rst_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              data_valid_o,
  output logic [CHAR_W:0]   data_o,
  output logic [1:0]        phase_o
);
  phase_e phase;
  logic   adv, word_done;

  assign adv = char_valid_i && (phase != PH_DATA);

  bpc_char_cnt #(.CHARS(CHARS_PER_WORD)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .last_o (word_done)
  );

  bpc_fsm #(.SYNC_WORDS(SYNC_WORDS), .DELIM_WORDS(DELIM_WORDS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (pending_i),
    .word_done_i (word_done),
    .phase_o     (phase),
    .laser_on_o  (laser_on_o),
    .path_rst_o  (path_rst_o)
  );

  bpc_word_gen #(.WORD_W(WORD_W), .DELIM_PATTERN(DELIM_PATTERN)) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_done_i  (word_done),
    .phase_i      (phase),
    .word_valid_o (word_valid_o),
    .word_o       (word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else begin
      data_valid_o <= char_valid_i && (phase == PH_DATA);
      if (char_valid_i && (phase == PH_DATA)) data_o <= {char_ctrl_i, char_i};
    end
  end

  assign phase_o = phase;
endmodule

// File: rtl/bpc_chk.sv
module bpc_chk #(
  parameter int                WORD_W        = 66,
  parameter logic [WORD_W-1:0] DELIM_PATTERN = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_valid_i,
  input logic              pending_i,
  input logic              laser_on_o,
  input logic              path_rst_o,
  input logic              word_valid_o,
  input logic [WORD_W-1:0] word_o,
  input logic              data_valid_o,
  input logic [1:0]        phase_o
);
  function automatic logic [WORD_W-1:0] alt_ref();
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = WORD_W - 1; i >= 0; i -= 2) r[i] = 1'b1;
    return r;
  endfunction

  localparam logic [WORD_W-1:0] ALT = alt_ref();

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3); // R2
  AST_WORD_NEEDS_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(char_valid_i) && ($past(phase_o) != 2'd2)); // R3
  AST_SYNC_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && ($past(phase_o) == 2'd0) |-> word_o == ALT); // R4
  AST_LASER_IN_CDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    laser_on_o |-> ($past(phase_o) == 2'd0) && $past(pending_i)); // R5
  AST_LASER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    laser_on_o |=> !laser_on_o); // R5
  AST_FRAME_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1) && ($past(phase_o) == 2'd0) |-> $past(pending_i) && word_valid_o); // R6
  AST_DELIM_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && ($past(phase_o) == 2'd1) |-> word_o == DELIM_PATTERN); // R7
  AST_RST_AT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_rst_o |-> (phase_o == 2'd2) && ($past(phase_o) == 2'd1)); // R8
  AST_ENTRY_HAS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2) && ($past(phase_o) == 2'd1) |-> path_rst_o); // R8
  AST_DATA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> ($past(phase_o) == 2'd2) && $past(char_valid_i)); // R9
  AST_DATA_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_o) == 2'd2) && !$past(pending_i) |-> phase_o == 2'd0); // R10
endmodule

bind burst_preamble_ctrl bpc_chk #(.WORD_W(WORD_W), .DELIM_PATTERN(DELIM_PATTERN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_valid_i (char_valid_i),
  .pending_i    (pending_i),
  .laser_on_o   (laser_on_o),
  .path_rst_o   (path_rst_o),
  .word_valid_o (word_valid_o),
  .word_o       (word_o),
  .data_valid_o (data_valid_o),
  .phase_o      (phase_o)
);

// File: tb/burst_preamble_ctrl_tb.sv
module burst_preamble_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CHAR_W = 8;
  localparam int WORD_W = 66;
  localparam int SYNC_W = 3;
  localparam int DELIM_W = 2;
  localparam logic [WORD_W-1:0] DELIM = 66'h1_0F0F_3C3C_A5A5_9669;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cv = 1'b0, cc = 1'b0, pend = 1'b0;
  logic [CHAR_W-1:0] cd = '0;
  logic laser, prst, wv, dv;
  logic [WORD_W-1:0] w;
  logic [CHAR_W:0] dq;
  logic [1:0] ph;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_preamble_ctrl #(
    .CHAR_W(CHAR_W), .WORD_W(WORD_W), .CHARS_PER_WORD(4),
    .SYNC_WORDS(SYNC_W), .DELIM_WORDS(DELIM_W), .DELIM_PATTERN(DELIM)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(cv), .char_i(cd), .char_ctrl_i(cc),
    .pending_i(pend), .laser_on_o(laser), .path_rst_o(prst), .word_valid_o(wv),
    .word_o(w), .data_valid_o(dv), .data_o(dq), .phase_o(ph)
  );

  typedef struct {
    logic              wv;
    logic [WORD_W-1:0] w;
    string             wtag;
    logic              dv;
    logic [CHAR_W:0]   d;
    logic              las;
    logic              prst;
    logic [1:0]        ph;
    string             ptag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_errors = 0;
  int m_ph = 0, m_cnt = 0, m_sync = 0, m_delim = 0;
  bit m_armed = 1'b1;
  bit done = 1'b0;

  function automatic logic [WORD_W-1:0] alt_word();
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = (i % 2 == 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // driver: drives one cycle and pushes the expected outcome
  task automatic step(input bit v, input logic [CHAR_W-1:0] d, input bit c, input bit p);
    exp_t e;
    int old;
    @(negedge clk);
    cv = v; cd = d; cc = c; pend = p;
    old = m_ph;
    e.wv = 0; e.w = '0; e.wtag = "R3"; e.dv = 0; e.d = '0; e.las = 0; e.prst = 0;
    case (m_ph)
      0: begin
        if (p && m_armed) begin e.las = 1; m_armed = 0; end
        if (v) begin
          if (m_cnt == 3) begin
            m_cnt = 0; e.wv = 1; e.w = alt_word(); e.wtag = "R4";
            if (p) begin
              if (m_sync == SYNC_W - 1) begin m_ph = 1; m_sync = 0; end
              else m_sync++;
            end
          end else m_cnt++;
        end
        if (!p) m_sync = 0;
      end
      1: if (v) begin
        if (m_cnt == 3) begin
          m_cnt = 0; e.wv = 1; e.w = DELIM; e.wtag = "R7";
          if (m_delim == DELIM_W - 1) begin m_ph = 2; m_delim = 0; e.prst = 1; end
          else m_delim++;
        end else m_cnt++;
      end
      default: begin
        e.dv = v; e.d = {c, d};
        if (!p) begin m_ph = 0; m_sync = 0; m_armed = 1; end
      end
    endcase
    e.ph = 2'(m_ph);
    if (old == 0 && m_ph == 1) e.ptag = "R6";
    else if (old == 1 && m_ph == 2) e.ptag = "R8";
    else if (old == 2 && m_ph == 0) e.ptag = "R10";
    else e.ptag = "R2";
    exp_q.push_back(e);
  endtask

  // monitor: compares each cycle's outputs away from the edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(wv == e.wv, "R3", "word_valid", WORD_W'(wv), WORD_W'(e.wv));
        if (e.wv) chk(w == e.w, e.wtag, "word", w, e.w);
        chk(dv == e.dv, "R9", "data_valid", WORD_W'(dv), WORD_W'(e.dv));
        if (e.dv) chk(dq == e.d, "R9", "data", WORD_W'(dq), WORD_W'(e.d));
        chk(laser == e.las, "R5", "laser_on", WORD_W'(laser), WORD_W'(e.las));
        chk(prst == e.prst, "R8", "path_rst", WORD_W'(prst), WORD_W'(e.prst));
        chk(ph == e.ph, e.ptag, "phase", WORD_W'(ph), WORD_W'(e.ph));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic run_burst(input bit gaps, input int seed);
    int guard = 0;
    // R6 R7: drive until data phase, toggling pending during the delimiter phase
    while (m_ph != 2 && guard < 200) begin
      step(1'b1, 8'(seed + guard), 1'b0, (m_ph == 1) ? 1'(guard % 2) : 1'b1);
      if (gaps) step(1'b0, 8'h00, 1'b0, 1'b1);
      guard++;
    end
    // R9: forward characters with mixed control flags
    for (int i = 0; i < 6; i++) step(i != 2, 8'(8'h40 + seed + i), 1'(i % 2), 1'b1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ph == 2'd0, "R1", "phase", WORD_W'(ph), '0);
    chk(!laser && !prst && !wv && !dv, "R1", "outputs",
        WORD_W'({laser, prst, wv, dv}), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 R3: nothing pending, continuous characters
    for (int i = 0; i < 8; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    // R3: characters on alternate cycles
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 8'(8'h10 + i), 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0);
    end
    // R5 R6: pending for five chars, then a drop that restarts the count
    for (int i = 0; i < 5; i++) step(1'b1, 8'(8'h20 + i), 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    run_burst(1'b0, 8'h30);
    // R10: pending drops in data phase
    step(1'b1, 8'h77, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 8'(8'h50 + i), 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    // R5 R10: second burst with gaps must request the laser again
    run_burst(1'b1, 8'h60);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h70 + i), 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule